// File: doc/BRIEF.md
# Reconfigurable Bit Crossbar with Parallel Configuration Port

This block connects a set of single-bit signal lines through a non-blocking crossbar. A square array of connection bits decides the paths. The bit at row `r` and column `c` makes source line `c` feed destination line `r`. One source may feed many destinations. A destination fed by several sources takes the OR of them, and a destination with no source reads 0. Every output passes through the same single register stage, so all paths have the same latency.

The array is changed through a write-only parallel port. The port carries a row address, a column address, a 2-bit operation code, a port/matrix select bit, a chip select and an asynchronous strobe. The strobe is synchronised into the system clock and edge-detected, so each pulse performs exactly one write, however long the pulse is. A write touches only its target cell or row, and every other path keeps passing data while the write takes place.

Two mode bits control the port. The enable bit opens the port. The attribute bit allows writes that are aimed at line attributes, which are held outside this block. Both bits are loaded from a strap pin during reset, and a side register port can overwrite them later. An attribute write changes nothing in the array. It only raises a one-cycle request that carries the address and the code.

Top module: `reconfig_xbar`

## Requirements
- R1: While `rst_n` is low, all connections are cleared and `line_out` is 0, and both mode bits (`mode_q[0]` = enable, `mode_q[1]` = attribute) take the value of `rc_pin`.
- R2: One clock after `line_in` is sampled, `line_out[r]` is the OR of `line_in[c]` over every connected `c`. A row with no connection outputs 0.
- R3: Operation code 2'b01 connects source `cfg_col` to destination `cfg_row`.
- R4: Operation code 2'b00 removes only the single connection at (`cfg_row`, `cfg_col`).
- R5: Operation code 2'b10 removes every connection of destination `cfg_row`. `cfg_col` is ignored.
- R6: Operation code 2'b11 changes nothing.
- R7: A write takes place only on a rising edge of the synchronised `cfg_strobe` while `cfg_sel` is high. A strobe that is held high performs exactly one write.
- R8: With the enable bit at 0, strobes change no connection and raise no attribute request.
- R9: With enable = 1 and attribute = 0, `cfg_ps` is treated as 0 and every write goes to the array.
- R10: With both mode bits at 1 and `cfg_ps` = 1, a write leaves the array unchanged. Instead, `attr_req` is high for one cycle, with `attr_row`, `attr_col` and `attr_code` holding the written values.
- R11: A high `mode_wr` loads `mode_wdata` into `mode_q` on the next clock edge.
- R12: Paths that a write does not target keep passing data, so one source that feeds several destinations drives all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_pin | input | 1 | Strap value for both mode bits during reset |
| line_in | input | N_LINES | Source lines |
| line_out | output | N_LINES | Registered destination lines |
| cfg_sel | input | 1 | Chip select of the configuration port |
| cfg_strobe | input | 1 | Asynchronous write strobe |
| cfg_ps | input | 1 | 1 = attribute write, 0 = array write |
| cfg_op | input | 2 | Operation code |
| cfg_row | input | AW | Row (destination) address |
| cfg_col | input | AW | Column (source) address |
| mode_wr | input | 1 | Side write of the mode bits |
| mode_wdata | input | 2 | New mode bits {attribute, enable} |
| mode_q | output | 2 | Current mode bits {attribute, enable} |
| attr_req | output | 1 | One-cycle attribute write request |
| attr_row | output | AW | Row address of the request |
| attr_col | output | AW | Column address of the request |
| attr_code | output | 2 | Operation code of the request |

## Verification
The OR fabric is driven with single-bit, multi-bit, all-zero and all-one input patterns. These separate a missing connection from a stuck one, one-to-many fan-out from many-to-one merging, and a correct OR from a stray AND or a passthrough. Each operation code is followed by a pattern that can only match the expected array, so a single-cell clear is told apart from a row clear and from a no-op. Long strobes, strobes without chip select, and each mode combination show whether a write happened, was ignored, or was redirected to an attribute request.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    OP_CLR_CELL = 2'b00,
    OP_SET_CELL = 2'b01,
    OP_CLR_ROW  = 2'b10,
    OP_NOP      = 2'b11
  } xbar_op_e;

  typedef struct packed {
    logic attr_ok;
    logic port_on;
  } xbar_mode_t;
endpackage

// File: rtl/xbar_strobe_sync.sv
module xbar_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic strobe_rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= strobe_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign strobe_rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/xbar_mode_reg.sv
module xbar_mode_reg
  import xbar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rc_pin,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  output xbar_mode_t mode
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode <= '{attr_ok: rc_pin, port_on: rc_pin};
    else if (mode_wr) mode <= xbar_mode_t'(mode_wdata);
endmodule

// File: rtl/xbar_cell_array.sv
module xbar_cell_array
  import xbar_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int AW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  xbar_op_e                        wr_op,
  input  logic [AW-1:0]                   wr_row,
  input  logic [AW-1:0]                   wr_col,
  output logic [N_LINES-1:0][N_LINES-1:0] conn
);
  genvar r;
  generate
    for (r = 0; r < N_LINES; r++) begin : g_row
      logic row_hit;
      assign row_hit = wr_en && (int'(wr_row) == r);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          conn[r] <= '0;
        end else if (row_hit) begin
          unique case (wr_op)
            OP_SET_CELL: if (int'(wr_col) < N_LINES) conn[r][wr_col] <= 1'b1;
            OP_CLR_CELL: if (int'(wr_col) < N_LINES) conn[r][wr_col] <= 1'b0;
            OP_CLR_ROW:  conn[r] <= '0;
            OP_NOP:      ;
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric #(
  parameter int N_LINES = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_LINES-1:0][N_LINES-1:0] conn,
  input  logic [N_LINES-1:0]              line_in,
  output logic [N_LINES-1:0]              line_out
);
  genvar r;
  generate
    for (r = 0; r < N_LINES; r++) begin : g_dst
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) line_out[r] <= 1'b0;
        else        line_out[r] <= |(conn[r] & line_in);
    end
  endgenerate
endmodule

// File: rtl/reconfig_xbar.sv
module reconfig_xbar
  import xbar_pkg::*;
#(
  parameter int N_LINES     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rc_pin,
  input  logic [N_LINES-1:0] line_in,
  output logic [N_LINES-1:0] line_out,
  input  logic               cfg_sel,
  input  logic               cfg_strobe,
  input  logic               cfg_ps,
  input  logic [1:0]         cfg_op,
  input  logic [AW-1:0]      cfg_row,
  input  logic [AW-1:0]      cfg_col,
  input  logic               mode_wr,
  input  logic [1:0]         mode_wdata,
  output logic [1:0]         mode_q,
  output logic               attr_req,
  output logic [AW-1:0]      attr_row,
  output logic [AW-1:0]      attr_col,
  output logic [1:0]         attr_code
);
  xbar_mode_t                      mode;
  logic                            strobe_rise;
  logic                            fire;
  logic                            ps_eff;
  logic                            cell_wr;
  logic [N_LINES-1:0][N_LINES-1:0] conn;

  xbar_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_async(cfg_strobe), .strobe_rise(strobe_rise)
  );

  xbar_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .rc_pin(rc_pin),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode(mode)
  );

  assign fire    = strobe_rise & cfg_sel & mode.port_on;
  assign ps_eff  = cfg_ps & mode.attr_ok;
  assign cell_wr = fire & ~ps_eff;
  assign mode_q  = mode;

  xbar_cell_array #(.N_LINES(N_LINES)) u_cells (
    .clk(clk), .rst_n(rst_n), .wr_en(cell_wr), .wr_op(xbar_op_e'(cfg_op)),
    .wr_row(cfg_row), .wr_col(cfg_col), .conn(conn)
  );

  xbar_fabric #(.N_LINES(N_LINES)) u_fabric (
    .clk(clk), .rst_n(rst_n), .conn(conn), .line_in(line_in), .line_out(line_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_req  <= 1'b0;
      attr_row  <= '0;
      attr_col  <= '0;
      attr_code <= '0;
    end else begin
      attr_req <= fire & ps_eff;
      if (fire & ps_eff) begin
        attr_row  <= cfg_row;
        attr_col  <= cfg_col;
        attr_code <= cfg_op;
      end
    end
  end
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int N_LINES = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_LINES*N_LINES-1:0] conn_flat,
  input logic                       strobe_rise,
  input logic [1:0]                 mode_q,
  input logic                       attr_req,
  input logic [N_LINES-1:0]         line_out
);
  always @(posedge clk)
    if (!rst_n)
      assert_reset_clear_R1: assert (conn_flat == '0 && line_out == '0)
        else $error("reset did not clear the array or the outputs");

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise);

  assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe_rise) |-> $stable(conn_flat));

  assert_port_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_q[0]) |-> ($stable(conn_flat) && !attr_req));

  assert_attr_needs_modes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    attr_req |-> ($past(mode_q) == 2'b11 && $past(strobe_rise) && $stable(conn_flat)));

  assert_attr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    attr_req |=> !attr_req);
endmodule

bind reconfig_xbar xbar_checker #(.N_LINES(N_LINES)) u_xbar_checker (
  .clk(clk), .rst_n(rst_n), .conn_flat(conn), .strobe_rise(strobe_rise),
  .mode_q(mode_q), .attr_req(attr_req), .line_out(line_out)
);

// File: tb/reconfig_xbar_bench.sv
module reconfig_xbar_bench;
  localparam int N  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rc_pin = 1'b1;
  logic [N-1:0]  line_in = '0;
  logic [N-1:0]  line_out;
  logic          cfg_sel = 1'b0, cfg_strobe = 1'b0, cfg_ps = 1'b0;
  logic [1:0]    cfg_op = 2'b11;
  logic [AW-1:0] cfg_row = '0, cfg_col = '0;
  logic          mode_wr = 1'b0;
  logic [1:0]    mode_wdata = '0;
  logic [1:0]    mode_q;
  logic          attr_req;
  logic [AW-1:0] attr_row, attr_col;
  logic [1:0]    attr_code;

  always #2 clk = ~clk;

  reconfig_xbar u_reconfig_xbar (.*);

  int checks = 0, fails = 0;
  int attr_cnt = 0;
  bit done = 0;
  logic [N-1:0] model [N];

  typedef struct { logic [N-1:0] exp; string tag; } item_t;
  item_t sbq[$];

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_out(input logic [N-1:0] in);
    logic [N-1:0] o;
    for (int r = 0; r < N; r++) o[r] = |(model[r] & in);
    return o;
  endfunction

  always @(negedge clk) begin
    if (attr_req) attr_cnt++;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(32'(line_out), 32'(it.exp), it.tag);
    end
  end

  task automatic expect_pattern(input logic [N-1:0] in, input string tag);
    line_in = in;
    repeat (2) @(negedge clk);
    sbq.push_back('{model_out(in), tag});
    repeat (2) @(negedge clk);
  endtask

  task automatic cfg_write(input logic ps, input logic [1:0] op, input int row,
                           input int col, input bit sel, input int hold);
    cfg_ps = ps; cfg_op = op; cfg_row = AW'(row); cfg_col = AW'(col); cfg_sel = sel;
    @(negedge clk);
    cfg_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    cfg_strobe = 1'b0;
    repeat (4) @(negedge clk);
    cfg_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic pin);
    rc_pin = pin;
    rst_n = 1'b0;
    for (int r = 0; r < N; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    check(32'(mode_q), {30'd0, pin, pin}, "R1 mode bits during reset");
    check(32'(line_out), 32'd0, "R1 outputs during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    do_reset(1'b1);
    expect_pattern('1, "R1 no connections after reset");

    // R3 / R2: single connection 5 -> 3
    cfg_write(1'b0, 2'b01, 3, 5, 1'b1, 3); model[3][5] = 1'b1;
    expect_pattern(N'(1) << 5, "R3 set cell drives destination");
    expect_pattern(~(N'(1) << 5), "R2 unconnected source gives 0");

    // R12: fan-out of line 5
    cfg_write(1'b0, 2'b01, 7, 5, 1'b1, 3); model[7][5] = 1'b1;
    cfg_write(1'b0, 2'b01, 9, 5, 1'b1, 3); model[9][5] = 1'b1;
    expect_pattern(N'(1) << 5, "R12 one source feeds many");

    // R2: many-to-one OR at row 3
    cfg_write(1'b0, 2'b01, 3, 1, 1'b1, 3); model[3][1] = 1'b1;
    expect_pattern(N'(1) << 1, "R2 OR first source");
    expect_pattern(16'h0022, "R2 OR both sources");
    expect_pattern('0, "R2 OR no source active");

    // R4: single-cell clear
    cfg_write(1'b0, 2'b00, 3, 5, 1'b1, 3); model[3][5] = 1'b0;
    expect_pattern('1, "R4 clear one cell only");

    // R6: no-op
    cfg_write(1'b0, 2'b11, 7, 5, 1'b1, 3);
    expect_pattern(N'(1) << 5, "R6 no-op keeps path");

    // R5: row clear ignores column
    cfg_write(1'b0, 2'b01, 9, 2, 1'b1, 3); model[9][2] = 1'b1;
    cfg_write(1'b0, 2'b10, 9, 0, 1'b1, 3); model[9] = '0;
    expect_pattern('1, "R5 row clear");

    // R7: strobe without chip select
    cfg_write(1'b0, 2'b01, 12, 4, 1'b0, 3);
    expect_pattern('1, "R7 no write without select");

    // R10: attribute write, long strobe gives one request
    base = attr_cnt;
    cfg_write(1'b1, 2'b01, 11, 6, 1'b1, 20);
    check(32'(attr_cnt - base), 32'd1, "R7 long strobe gives one write");
    check(32'({attr_row, attr_col, attr_code}), 32'({4'd11, 4'd6, 2'b01}), "R10 request fields");
    expect_pattern('1, "R10 attribute write leaves array");

    // R11 / R9: attribute bit off
    mode_wdata = 2'b01; mode_wr = 1'b1; @(negedge clk); mode_wr = 1'b0;
    check(32'(mode_q), 32'd1, "R11 mode write");
    base = attr_cnt;
    cfg_write(1'b1, 2'b01, 11, 6, 1'b1, 3); model[11][6] = 1'b1;
    check(32'(attr_cnt - base), 32'd0, "R9 no request when attribute bit off");
    expect_pattern(N'(1) << 6, "R9 select forced to array");

    // R8: port disabled
    mode_wdata = 2'b10; mode_wr = 1'b1; @(negedge clk); mode_wr = 1'b0;
    base = attr_cnt;
    cfg_write(1'b0, 2'b10, 7, 0, 1'b1, 3);
    cfg_write(1'b1, 2'b01, 0, 0, 1'b1, 3);
    check(32'(attr_cnt - base), 32'd0, "R8 no request when disabled");
    expect_pattern(N'(1) << 5, "R8 writes ignored when disabled");

    // R1: reset with strap low clears everything
    do_reset(1'b0);
    expect_pattern('1, "R1 array cleared by reset");

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule